// File: doc/BRIEF.md
# Flash Erased-Range Verify Sequencer

This block checks that a run of consecutive phrases in a flash array reads back as fully erased, meaning every bit is 1. Software first fills a small file of byte-wide parameter slots. The slots hold a command code, a 24-bit start address, a 16-bit phrase count and a read-margin selector. Software then pulses a launch strobe while the command-complete flag is high. Launching drops that flag and clears both status bits.

The sequencer spends one cycle validating the parameters. If any parameter is bad, it raises an access error and never touches the memory. Otherwise it streams one read per cycle over the phrase range, stepping 8 bytes each time. It compares each returned word against all ones and raises verify-fail on any zero bit. It finishes with a drain cycle and then raises command-complete again.

The margin selector rides on every read as a 2-bit sideband, so the memory model can show weak bits under the tighter margins.

The controller is a five-state machine:
- **IDLE**: complete flag high; waits for launch. Transition *launch*: IDLE→CHECK.
- **CHECK**: parameters judged; loads the address generator. Transitions *params good*: CHECK→SCAN, and *params bad*: CHECK→FAULT.
- **SCAN**: one read per cycle. Transitions *more phrases*: SCAN→SCAN, and *last phrase issued*: SCAN→DRAIN.
- **DRAIN**: the final word is compared. Transition *finish*: DRAIN→IDLE.
- **FAULT**: the access error is already recorded. Transition *abort*: FAULT→IDLE.

Top module: `erase_verify_seq`

## Requirements
- R1: After reset, `done` is 1, and `acc_err`, `vfy_fail` and `mem_rd` are 0.
- R2: A write with `slot_wr` loads `slot_wdata` into the slot selected by `slot_idx`. The slots are: 0 = command code; 1, 2, 3 = start address bits [23:16], [15:8], [7:0]; 4, 5 = phrase count bits [15:8], [7:0]; 6 = margin selector. Indices 7 and above are ignored. Writes made while `done` is 0 are ignored.
- R3: A `launch` pulse sampled while `done` is 1 makes `done`, `acc_err` and `vfy_fail` read 0 in the next cycle. A `launch` pulse sampled while `done` is 0 has no effect on the run in progress.
- R4: Any of the following sets `acc_err` one cycle after the check cycle:
  - the command code is not 0x01;
  - the margin is above 0x02;
  - start address bits [1:0] are not 00;
  - the start address is at or beyond the flash size;
  - the phrase count is 0;
  - start + 8×count exceeds the flash size.

  In that case `mem_rd` never rises, and `done` returns exactly 2 cycles after the launch edge.
- R5: A valid command issues exactly `count` reads on consecutive cycles, at addresses start, start+8, start+16, and so on. Each read carries `mem_margin` equal to the margin code: 0x00 = normal, 0x01 = user margin, 0x02 = factory margin.
- R6: `mem_rdata` is taken as valid one cycle after each read. If any such word has a 0 bit, `vfy_fail` is set. Otherwise `vfy_fail` stays 0.
- R7: For a valid command, `done` returns exactly count+2 cycles after the launch edge. This is one cycle after the last compare.
- R8: A range that ends exactly at the flash size is accepted. So is a start address that is 4-byte but not 8-byte aligned.
- R9: A slot write sampled in the same cycle as an accepted launch takes effect for that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_wr | input | 1 | Parameter slot write enable |
| slot_idx | input | 3 | Parameter slot index |
| slot_wdata | input | 8 | Parameter slot write data |
| launch | input | 1 | Start strobe (clears the complete flag) |
| done | output | 1 | Command-complete flag |
| acc_err | output | 1 | Access error: a parameter was rejected |
| vfy_fail | output | 1 | Verify failure: a bit read as 0 |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 24 | Byte address of the phrase being read |
| mem_margin | output | 2 | Read-margin sideband |
| mem_rdata | input | DATA_W | Phrase data, valid the cycle after `mem_rd` |

## Verification
Two events can coincide at the edge where a command is accepted: a parameter slot write and the launch strobe. The bench drives both in the same cycle, first turning a good margin into an illegal one and then the reverse. It judges the outcome by whether `acc_err` rises two cycles later and whether any reads appear. A second coincidence is the final phrase compare landing in the drain cycle just before completion. A zero bit planted in the last phrase must show as `vfy_fail` in the same cycle that `done` returns.

// File: rtl/efv_pkg.sv
package efv_pkg;
    localparam int ADDR_W    = 24;
    localparam int CNT_W     = 16;
    localparam int NUM_SLOTS = 7;
    localparam int IDX_W     = 3;

    localparam int SLOT_CODE   = 0;
    localparam int SLOT_ADDR_H = 1;
    localparam int SLOT_ADDR_M = 2;
    localparam int SLOT_ADDR_L = 3;
    localparam int SLOT_CNT_H  = 4;
    localparam int SLOT_CNT_L  = 5;
    localparam int SLOT_MARGIN = 6;

    localparam logic [7:0] MARGIN_MAX = 8'h02;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SCAN,
        ST_DRAIN,
        ST_FAULT
    } efv_state_t;
endpackage

// File: rtl/efv_cmd_regs.sv
module efv_cmd_regs
    import efv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [7:0]        wr_data,
    output logic [7:0]        cmd_code,
    output logic [ADDR_W-1:0] start_addr,
    output logic [CNT_W-1:0]  phrase_cnt,
    output logic [7:0]        margin_sel
);
    logic [7:0] slot_q [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= 8'h00;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    assign cmd_code   = slot_q[SLOT_CODE];
    assign start_addr = {slot_q[SLOT_ADDR_H], slot_q[SLOT_ADDR_M], slot_q[SLOT_ADDR_L]};
    assign phrase_cnt = {slot_q[SLOT_CNT_H], slot_q[SLOT_CNT_L]};
    assign margin_sel = slot_q[SLOT_MARGIN];
endmodule

// File: rtl/efv_param_chk.sv
module efv_param_chk
    import efv_pkg::*;
#(
    parameter int         FLASH_BYTES  = 524288,
    parameter int         PHRASE_BYTES = 8,
    parameter logic [7:0] VERIFY_CODE  = 8'h01
) (
    input  logic [7:0]        cmd_code,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  phrase_cnt,
    input  logic [7:0]        margin_sel,
    output logic              params_ok
);
    localparam int SHIFT = $clog2(PHRASE_BYTES);
    localparam int EXT_W = ADDR_W + CNT_W + SHIFT + 1;

    logic [EXT_W-1:0] start_x, span_x, end_x, limit_x;
    logic bad_code, bad_margin, bad_align, bad_start, bad_cnt, bad_span;

    always_comb begin
        start_x    = EXT_W'(start_addr);
        span_x     = EXT_W'(phrase_cnt) << SHIFT;
        end_x      = start_x + span_x;
        limit_x    = EXT_W'(FLASH_BYTES);
        bad_code   = (cmd_code != VERIFY_CODE);
        bad_margin = (margin_sel > MARGIN_MAX);
        bad_align  = (start_addr[1:0] != 2'b00);
        bad_start  = (start_x >= limit_x);
        bad_cnt    = (phrase_cnt == '0);
        bad_span   = (end_x > limit_x);
        params_ok  = !(bad_code || bad_margin || bad_align ||
                       bad_start || bad_cnt || bad_span);
    end
endmodule

// File: rtl/efv_addr_gen.sv
module efv_addr_gen
    import efv_pkg::*;
#(
    parameter int PHRASE_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  phrase_cnt,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr   <= '0;
            left_q <= '0;
        end else if (load) begin
            addr   <= start_addr;
            left_q <= phrase_cnt;
        end else if (step) begin
            addr   <= addr + ADDR_W'(PHRASE_BYTES);
            left_q <= left_q - 1'b1;
        end
    end

    assign last = (left_q == CNT_W'(1));
endmodule

// File: rtl/erase_verify_seq.sv
module erase_verify_seq
    import efv_pkg::*;
#(
    parameter int         FLASH_BYTES  = 524288,
    parameter int         PHRASE_BYTES = 8,
    parameter int         DATA_W       = 64,
    parameter logic [7:0] VERIFY_CODE  = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_wr,
    input  logic [2:0]        slot_idx,
    input  logic [7:0]        slot_wdata,
    input  logic              launch,
    output logic              done,
    output logic              acc_err,
    output logic              vfy_fail,
    output logic              mem_rd,
    output logic [23:0]       mem_addr,
    output logic [1:0]        mem_margin,
    input  logic [DATA_W-1:0] mem_rdata
);
    efv_state_t state_q, state_d;

    logic [7:0]        cmd_code, margin_sel;
    logic [ADDR_W-1:0] start_addr, gen_addr;
    logic [CNT_W-1:0]  phrase_cnt;
    logic              params_ok, gen_last, rvalid_q;
    logic              idle, accept;

    assign idle   = (state_q == ST_IDLE);
    assign accept = idle && launch;

    efv_cmd_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (slot_wr && idle),
        .wr_idx     (slot_idx),
        .wr_data    (slot_wdata),
        .cmd_code   (cmd_code),
        .start_addr (start_addr),
        .phrase_cnt (phrase_cnt),
        .margin_sel (margin_sel)
    );

    efv_param_chk #(
        .FLASH_BYTES  (FLASH_BYTES),
        .PHRASE_BYTES (PHRASE_BYTES),
        .VERIFY_CODE  (VERIFY_CODE)
    ) u_chk (
        .cmd_code   (cmd_code),
        .start_addr (start_addr),
        .phrase_cnt (phrase_cnt),
        .margin_sel (margin_sel),
        .params_ok  (params_ok)
    );

    efv_addr_gen #(
        .PHRASE_BYTES (PHRASE_BYTES)
    ) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (state_q == ST_CHECK),
        .step       (state_q == ST_SCAN),
        .start_addr (start_addr),
        .phrase_cnt (phrase_cnt),
        .addr       (gen_addr),
        .last       (gen_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch) state_d = ST_CHECK;
            ST_CHECK: state_d = params_ok ? ST_SCAN : ST_FAULT;
            ST_SCAN:  if (gen_last) state_d = ST_DRAIN;
            ST_DRAIN: state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        done       = idle;
        mem_rd     = (state_q == ST_SCAN);
        mem_addr   = gen_addr;
        mem_margin = margin_sel[1:0];
    end

    // Status flags and read-data tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            acc_err  <= 1'b0;
            vfy_fail <= 1'b0;
        end else begin
            rvalid_q <= mem_rd;
            if (accept) begin
                acc_err  <= 1'b0;
                vfy_fail <= 1'b0;
            end else begin
                if (state_q == ST_CHECK && !params_ok) acc_err <= 1'b1;
                if (rvalid_q && (mem_rdata != '1))     vfy_fail <= 1'b1;
            end
        end
    end

    p_launch_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && launch) |=> (!done && !acc_err && !vfy_fail));

    p_no_read_on_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> !mem_rd);

    p_fault_then_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_err) |=> done);

    p_status_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_err && vfy_fail));

    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + 24'(PHRASE_BYTES)));

    p_margin_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_margin != 2'b11));

    p_margin_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> $stable(mem_margin));
endmodule

// File: tb/erase_verify_seq_bench.sv
module erase_verify_seq_bench;
    localparam int FLASH = 524288;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_wr = 1'b0;
    logic [2:0]  slot_idx = '0;
    logic [7:0]  slot_wdata = '0;
    logic        launch = 1'b0;
    logic        done, acc_err, vfy_fail, mem_rd;
    logic [23:0] mem_addr;
    logic [1:0]  mem_margin;
    logic [63:0] mem_rdata = '1;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // memory model and read monitor state
    logic [23:0] bad_addr  = 24'hFFFFFF;
    logic [23:0] weak_addr = 24'hFFFFFF;
    logic [23:0] exp_addr  = '0;
    logic [1:0]  exp_margin = '0;
    logic [23:0] cur_start = '0;
    int nrd = 0, addr_bad = 0, marg_bad = 0;

    always #2 clk = ~clk;

    erase_verify_seq u_erase_verify_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_wr    (slot_wr),
        .slot_idx   (slot_idx),
        .slot_wdata (slot_wdata),
        .launch     (launch),
        .done       (done),
        .acc_err    (acc_err),
        .vfy_fail   (vfy_fail),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .mem_margin (mem_margin),
        .mem_rdata  (mem_rdata)
    );

    // memory: erased everywhere; one hard zero at bad_addr, one weak bit
    // visible only under the factory margin at weak_addr
    always @(posedge clk) begin
        if (mem_rd) begin
            logic [63:0] w;
            w = '1;
            if (mem_addr == bad_addr) w[5] = 1'b0;
            if (mem_addr == weak_addr && mem_margin == 2'd2) w[63] = 1'b0;
            mem_rdata <= w;
            if (mem_addr != exp_addr) addr_bad++;
            if (mem_margin != exp_margin) marg_bad++;
            exp_addr <= exp_addr + 24'd8;
            nrd++;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic write_slot(input logic [2:0] idx, input logic [7:0] dat);
        @(negedge clk);
        slot_wr = 1'b1; slot_idx = idx; slot_wdata = dat;
        @(negedge clk);
        slot_wr = 1'b0;
    endtask

    task automatic set_cmd(input logic [7:0] code, input logic [23:0] addr,
                           input logic [15:0] cnt, input logic [7:0] marg);
        write_slot(3'd0, code);
        write_slot(3'd1, addr[23:16]);
        write_slot(3'd2, addr[15:8]);
        write_slot(3'd3, addr[7:0]);
        write_slot(3'd4, cnt[15:8]);
        write_slot(3'd5, cnt[7:0]);
        write_slot(3'd6, marg);
        cur_start  = addr;
        exp_margin = marg[1:0];
    endtask

    task automatic run_cmd(input string tag, input int exp_lat, input bit exp_acc,
                           input bit exp_vf, input int exp_reads, input bit co_wr,
                           input logic [2:0] co_idx, input logic [7:0] co_dat);
        int cyc;
        nrd = 0; addr_bad = 0; marg_bad = 0; exp_addr = cur_start;
        @(negedge clk);
        launch = 1'b1;
        if (co_wr) begin slot_wr = 1'b1; slot_idx = co_idx; slot_wdata = co_dat; end
        @(negedge clk);
        launch = 1'b0; slot_wr = 1'b0;
        chk("R3", "done cleared by launch", int'(done), 0);
        chk("R3", "acc_err cleared by launch", int'(acc_err), 0);
        chk("R3", "vfy_fail cleared by launch", int'(vfy_fail), 0);
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk(tag, "completion latency", cyc, exp_lat);
        chk(tag, "acc_err", int'(acc_err), int'(exp_acc));
        chk(tag, "vfy_fail", int'(vfy_fail), int'(exp_vf));
        chk(tag, "read count", nrd, exp_reads);
        chk(tag, "address sequence mismatches", addr_bad, 0);
        chk(tag, "margin sideband mismatches", marg_bad, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "done after reset", int'(done), 1);
        chk("R1", "acc_err after reset", int'(acc_err), 0);
        chk("R1", "vfy_fail after reset", int'(vfy_fail), 0);
        chk("R1", "mem_rd after reset", int'(mem_rd), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_clean_pass;
        set_cmd(8'h01, 24'h000100, 16'd4, 8'h00);
        run_cmd("R7", 6, 1'b0, 1'b0, 4, 1'b0, 3'd0, 8'h00);
        set_cmd(8'h01, 24'h001000, 16'd1, 8'h00);
        run_cmd("R5", 3, 1'b0, 1'b0, 1, 1'b0, 3'd0, 8'h00);
    endtask

    task automatic t_fail_last;
        bad_addr = 24'h000100 + 24'd24;
        set_cmd(8'h01, 24'h000100, 16'd4, 8'h00);
        run_cmd("R6", 6, 1'b0, 1'b1, 4, 1'b0, 3'd0, 8'h00);
        bad_addr = 24'h000200;
        set_cmd(8'h01, 24'h000200, 16'd3, 8'h01);
        run_cmd("R6", 5, 1'b0, 1'b1, 3, 1'b0, 3'd0, 8'h00);
        bad_addr = 24'hFFFFFF;
    endtask

    task automatic t_margins;
        weak_addr = 24'h000410;
        set_cmd(8'h01, 24'h000400, 16'd5, 8'h00);
        run_cmd("R5", 7, 1'b0, 1'b0, 5, 1'b0, 3'd0, 8'h00);
        set_cmd(8'h01, 24'h000400, 16'd5, 8'h01);
        run_cmd("R5", 7, 1'b0, 1'b0, 5, 1'b0, 3'd0, 8'h00);
        set_cmd(8'h01, 24'h000400, 16'd5, 8'h02);
        run_cmd("R5", 7, 1'b0, 1'b1, 5, 1'b0, 3'd0, 8'h00);
        weak_addr = 24'hFFFFFF;
    endtask

    task automatic t_param_errors;
        set_cmd(8'h01, 24'h000100, 16'd4, 8'h03);
        run_cmd("R4", 2, 1'b1, 1'b0, 0, 1'b0, 3'd0, 8'h00);
        set_cmd(8'h01, 24'h000102, 16'd4, 8'h00);
        run_cmd("R4", 2, 1'b1, 1'b0, 0, 1'b0, 3'd0, 8'h00);
        set_cmd(8'h01, 24'h080000, 16'd1, 8'h00);
        run_cmd("R4", 2, 1'b1, 1'b0, 0, 1'b0, 3'd0, 8'h00);
        set_cmd(8'h01, 24'h000100, 16'd0, 8'h00);
        run_cmd("R4", 2, 1'b1, 1'b0, 0, 1'b0, 3'd0, 8'h00);
        set_cmd(8'h01, 24'h07FFF8, 16'd2, 8'h00);
        run_cmd("R4", 2, 1'b1, 1'b0, 0, 1'b0, 3'd0, 8'h00);
        set_cmd(8'h01, 24'h07FFFC, 16'd1, 8'h00);
        run_cmd("R4", 2, 1'b1, 1'b0, 0, 1'b0, 3'd0, 8'h00);
        set_cmd(8'h02, 24'h000100, 16'd4, 8'h00);
        run_cmd("R4", 2, 1'b1, 1'b0, 0, 1'b0, 3'd0, 8'h00);
    endtask

    task automatic t_boundaries;
        set_cmd(8'h01, 24'h07FFF8, 16'd1, 8'h00);
        run_cmd("R8", 3, 1'b0, 1'b0, 1, 1'b0, 3'd0, 8'h00);
        set_cmd(8'h01, 24'h07FF00, 16'd32, 8'h00);
        run_cmd("R8", 34, 1'b0, 1'b0, 32, 1'b0, 3'd0, 8'h00);
        set_cmd(8'h01, 24'h000104, 16'd2, 8'h00);
        run_cmd("R8", 4, 1'b0, 1'b0, 2, 1'b0, 3'd0, 8'h00);
    endtask

    task automatic t_busy_ignored;
        set_cmd(8'h01, 24'h002000, 16'd20, 8'h00);
        fork
            run_cmd("R3", 22, 1'b0, 1'b0, 20, 1'b0, 3'd0, 8'h00);
            begin
                repeat (6) @(negedge clk);
                launch = 1'b1; slot_wr = 1'b1; slot_idx = 3'd6; slot_wdata = 8'h09;
                @(negedge clk);
                launch = 1'b0; slot_wr = 1'b0;
            end
        join
        // the margin write during the run must not have landed
        run_cmd("R2", 22, 1'b0, 1'b0, 20, 1'b0, 3'd0, 8'h00);
        // index 7 is not a slot
        write_slot(3'd7, 8'hFF);
        run_cmd("R2", 22, 1'b0, 1'b0, 20, 1'b0, 3'd0, 8'h00);
    endtask

    task automatic t_same_cycle;
        set_cmd(8'h01, 24'h000300, 16'd3, 8'h00);
        run_cmd("R9", 2, 1'b1, 1'b0, 0, 1'b1, 3'd6, 8'h07);
        run_cmd("R9", 5, 1'b0, 1'b0, 3, 1'b1, 3'd6, 8'h00);
    endtask

    initial begin
        t_reset();
        t_clean_pass();
        t_fail_last();
        t_margins();
        t_param_errors();
        t_boundaries();
        t_busy_ignored();
        t_same_cycle();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule